// File: doc/BRIEF.md
# Operand Barrel Shifter with Shifter Carry

This block turns a 32-bit register value into the second operand of an arithmetic/logic unit and produces the carry that the shift operation generates. The caller picks one of four shift kinds and one of two sources for the shift amount. The amount comes either from a 5-bit field held in the instruction or from the low byte of a second register. The current carry flag goes in alongside the data. It feeds the pass-through cases and the one-bit extended rotate.

The two amount sources do not treat a zero amount the same way. In the instruction-field form, a zero amount is a special encoding that means something different for each shift kind. In the register form, a zero byte always passes the data through, and amounts of 32 or more have defined results. The shifted operand and its carry are captured in one output register. That register loads on every clock where the advance enable is high and holds its value otherwise.

Top module: `barrel_shift_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released without an advance, `op_q` is all zeros and `carry_q` is 0.
- R2: On a clock where `step_en` is 0, `op_q` and `carry_q` keep their values whatever the other inputs do. When `step_en` is 1, the result for the inputs present at that edge appears on the outputs after that edge (one cycle of latency).
- R3: `shift_kind` encodes 00 = shift left logical, 01 = shift right logical, 10 = shift right arithmetic, 11 = rotate right. For an amount n from 1 to 31: left shift fills the low bits with zeros, logical right fills the high bits with zeros, arithmetic right fills the high bits with `rm[31]`, and rotate right moves the bits that leave the low end into the high end.
- R4: For amounts n from 1 to 31, the carry out is the last bit that leaves the word. That is `rm[32-n]` for a left shift and `rm[n-1]` for the three right operations.
- R5: With `amt_src_reg` = 0, a left shift with `imm_amt` = 0 gives `rm` unchanged, and the carry out is `c_in`.
- R6: With `amt_src_reg` = 0, a logical right shift with `imm_amt` = 0 acts as a shift by 32. The result is zero and the carry is `rm[31]`.
- R7: With `amt_src_reg` = 0, an arithmetic right shift with `imm_amt` = 0 acts as a shift by 32. Every result bit and the carry equal `rm[31]`.
- R8: With `amt_src_reg` = 0, a rotate with `imm_amt` = 0 is an extended rotate through carry. The result is `{c_in, rm[31:1]}` and the carry is `rm[0]`.
- R9: With `amt_src_reg` = 1 and `reg_amt` = 0, every shift kind gives `rm` unchanged with carry `c_in`.
- R10: With `amt_src_reg` = 1, a left or logical right shift by exactly 32 gives zero, with carry `rm[0]` for left and `rm[31]` for right. By more than 32, it gives zero with carry 0.
- R11: With `amt_src_reg` = 1, an arithmetic right shift by 32 or more gives all bits equal to `rm[31]`, with carry `rm[31]`.
- R12: With `amt_src_reg` = 1, a rotate uses `reg_amt` modulo 32. A nonzero multiple of 32 gives `rm` with carry `rm[31]`. Any other value rotates by the low 5 bits, with carry equal to the last bit rotated out.
- R13: The unselected amount input has no effect. `imm_amt` is ignored when `amt_src_reg` = 1, and `reg_amt` is ignored when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advance enable for the output register |
| amt_src_reg | input | 1 | 0 = amount from `imm_amt`, 1 = amount from `reg_amt` |
| shift_kind | input | 2 | Shift kind (encoding in R3) |
| imm_amt | input | 5 | Instruction-field shift amount |
| reg_amt | input | 8 | Register shift amount (low byte of the amount register) |
| rm | input | 32 | Data to be shifted |
| c_in | input | 1 | Current carry flag |
| op_q | output | 32 | Registered shifted operand |
| carry_q | output | 1 | Registered shifter carry out |

## Verification
The only state in this block is the output register, so a wrong amount classification or wrong rotator control shows up at the ports on the very next advanced clock. The symptom is a wrong operand bit or a wrong carry for that single vector. The dangerous corners therefore sit at the edges of the amount classes: the instruction-field zero for each kind, register amounts of 0, 31, 32, 33 and the multiples of 32, and the distinct carry index used for left shifts. Each of these is compared against a behavioural model on every clock. A stuck enable or a register that does not hold shows as a mismatch in the first cycle in which the inputs change while `step_en` is low.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  // Class of the effective amount after the zero/large-amount rules
  typedef enum logic [2:0] {
    CL_PASS   = 3'd0,  // data through, carry from c_in
    CL_PART   = 3'd1,  // amount 1 .. WIDTH-1
    CL_FULL   = 3'd2,  // amount exactly WIDTH (or ROR multiple of WIDTH)
    CL_BEYOND = 3'd3,  // amount above WIDTH (LSL/LSR/ASR only)
    CL_EXTEND = 3'd4   // one-bit rotate through carry
  } amt_class_e;

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
  import shf_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(WIDTH)
) (
  input  logic                 amt_src_reg,
  input  shift_kind_e          kind,
  input  logic [AMT_W-1:0]     imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  output amt_class_e           cls,
  output logic [AMT_W-1:0]     part_amt
);

  localparam logic [REG_AMT_W-1:0] W_REG = REG_AMT_W'(WIDTH);

  logic [AMT_W-1:0] reg_low;
  assign reg_low = reg_amt[AMT_W-1:0];

  always_comb begin
    cls      = CL_PASS;
    part_amt = '0;
    if (!amt_src_reg) begin
      if (imm_amt == '0) begin
        unique case (kind)
          SH_LSL:         cls = CL_PASS;
          SH_LSR, SH_ASR: cls = CL_FULL;
          default:        cls = CL_EXTEND;
        endcase
      end else begin
        cls      = CL_PART;
        part_amt = imm_amt;
      end
    end else if (reg_amt == '0) begin
      cls = CL_PASS;
    end else if (kind == SH_ROR) begin
      if (reg_low == '0) begin
        cls = CL_FULL;
      end else begin
        cls      = CL_PART;
        part_amt = reg_low;
      end
    end else if (reg_amt < W_REG) begin
      cls      = CL_PART;
      part_amt = reg_low;
    end else if (reg_amt == W_REG) begin
      cls = CL_FULL;
    end else begin
      cls = CL_BEYOND;
    end
  end

endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int WIDTH  = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] rot_amt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    always_comb begin
      if (rot_amt[s]) begin
        stage[s+1] = {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]};
      end else begin
        stage[s+1] = stage[s];
      end
    end
  end

  assign dout = stage[AMT_W];

endmodule

// File: rtl/shf_result_mux.sv
module shf_result_mux
  import shf_pkg::*;
#(
  parameter int WIDTH  = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  shift_kind_e      kind,
  input  amt_class_e       cls,
  input  logic [AMT_W-1:0] part_amt,
  input  logic [WIDTH-1:0] rm,
  input  logic [WIDTH-1:0] rot,
  input  logic             c_in,
  output logic [WIDTH-1:0] op,
  output logic             carry
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic             sign;
  logic [WIDTH-1:0] keep_low;
  logic [WIDTH-1:0] keep_high;
  logic [WIDTH-1:0] sign_fill;

  assign sign      = rm[WIDTH-1];
  assign keep_low  = ALL_ONES >> part_amt;
  assign keep_high = ALL_ONES << part_amt;
  assign sign_fill = {WIDTH{sign}};

  always_comb begin
    op    = rm;
    carry = c_in;
    unique case (cls)
      CL_PASS: begin
        op    = rm;
        carry = c_in;
      end
      CL_EXTEND: begin
        op    = {c_in, rm[WIDTH-1:1]};
        carry = rm[0];
      end
      CL_FULL: begin
        unique case (kind)
          SH_LSL: begin op = '0;        carry = rm[0]; end
          SH_LSR: begin op = '0;        carry = sign;  end
          SH_ASR: begin op = sign_fill; carry = sign;  end
          default: begin op = rm;       carry = sign;  end
        endcase
      end
      CL_BEYOND: begin
        if (kind == SH_ASR) begin
          op    = sign_fill;
          carry = sign;
        end else begin
          op    = '0;
          carry = 1'b0;
        end
      end
      CL_PART: begin
        unique case (kind)
          SH_LSL: begin op = rot & keep_high; carry = rot[0]; end
          SH_LSR: begin op = rot & keep_low;  carry = rot[WIDTH-1]; end
          SH_ASR: begin
            op    = (rot & keep_low) | (sign_fill & ~keep_low);
            carry = rot[WIDTH-1];
          end
          default: begin op = rot; carry = rot[WIDTH-1]; end
        endcase
      end
      default: begin
        op    = rm;
        carry = c_in;
      end
    endcase
  end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shf_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(WIDTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 amt_src_reg,
  input  logic [1:0]           shift_kind,
  input  logic [AMT_W-1:0]     imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  input  logic [WIDTH-1:0]     rm,
  input  logic                 c_in,
  output logic [WIDTH-1:0]     op_q,
  output logic                 carry_q
);

  shift_kind_e      kind;
  amt_class_e       cls;
  logic [AMT_W-1:0] part_amt;
  logic [AMT_W-1:0] rot_amt;
  logic [WIDTH-1:0] rot;
  logic [WIDTH-1:0] op_c;
  logic             carry_c;
  logic [WIDTH-1:0] op_d;
  logic             carry_d;

  assign kind = shift_kind_e'(shift_kind);

  shf_amount_decode #(.WIDTH(WIDTH), .REG_AMT_W(REG_AMT_W)) i_decode (
    .amt_src_reg (amt_src_reg),
    .kind        (kind),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .cls         (cls),
    .part_amt    (part_amt)
  );

  // A left shift by n is a right rotate by WIDTH-n followed by a mask
  assign rot_amt = (kind == SH_LSL) ? (AMT_W'(0) - part_amt) : part_amt;

  shf_rotator #(.WIDTH(WIDTH)) i_rotator (
    .din     (rm),
    .rot_amt (rot_amt),
    .dout    (rot)
  );

  shf_result_mux #(.WIDTH(WIDTH)) i_result (
    .kind     (kind),
    .cls      (cls),
    .part_amt (part_amt),
    .rm       (rm),
    .rot      (rot),
    .c_in     (c_in),
    .op       (op_c),
    .carry    (carry_c)
  );

  always_comb begin
    op_d    = op_q;
    carry_d = carry_q;
    if (step_en) begin
      op_d    = op_c;
      carry_d = carry_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      carry_q <= carry_d;
    end
  end

  // R2: no advance, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(op_q) && $stable(carry_q)));

  // R5: instruction-field left shift by zero passes data and carry
  p_imm_lsl0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !amt_src_reg && shift_kind == 2'b00 && imm_amt == '0)
    |=> (op_q == $past(rm) && carry_q == $past(c_in)));

  // R6: instruction-field logical right by zero acts as shift by WIDTH
  p_imm_lsr0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !amt_src_reg && shift_kind == 2'b01 && imm_amt == '0)
    |=> (op_q == '0 && carry_q == $past(rm[WIDTH-1])));

  // R7: instruction-field arithmetic right by zero gives a uniform word
  p_imm_asr0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !amt_src_reg && shift_kind == 2'b10 && imm_amt == '0)
    |=> (($countones(op_q) == 0 || $countones(op_q) == WIDTH)
         && op_q[0] == carry_q && carry_q == $past(rm[WIDTH-1])));

  // R8: instruction-field rotate by zero is the extended rotate
  p_imm_rrx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !amt_src_reg && shift_kind == 2'b11 && imm_amt == '0)
    |=> (op_q == {$past(c_in), $past(rm[WIDTH-1:1])} && carry_q == $past(rm[0])));

  // R9: register amount of zero passes data and carry for every kind
  p_reg_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && amt_src_reg && reg_amt == '0)
    |=> (op_q == $past(rm) && carry_q == $past(c_in)));

  // R10: logical shifts beyond the word give zero and a clear carry
  p_reg_beyond_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && amt_src_reg && !shift_kind[1] && reg_amt > REG_AMT_W'(WIDTH))
    |=> (op_q == '0 && !carry_q));

  // R11: arithmetic right by WIDTH or more leaves only sign copies
  p_reg_asr_big_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && amt_src_reg && shift_kind == 2'b10 && reg_amt >= REG_AMT_W'(WIDTH))
    |=> (op_q == {WIDTH{$past(rm[WIDTH-1])}} && carry_q == $past(rm[WIDTH-1])));

endmodule

// File: tb/test_barrel_shift_unit.sv
module test_barrel_shift_unit;

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic        amt_src_reg;
  logic [1:0]  shift_kind;
  logic [4:0]  imm_amt;
  logic [7:0]  reg_amt;
  logic [31:0] rm;
  logic        c_in;
  logic [31:0] op_q;
  logic        carry_q;

  int n_checks;
  int n_fails;
  logic [32:0] exp_q;

  barrel_shift_unit i_barrel_shift_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .amt_src_reg (amt_src_reg),
    .shift_kind  (shift_kind),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .rm          (rm),
    .c_in        (c_in),
    .op_q        (op_q),
    .carry_q     (carry_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Behavioural model: returns {carry, operand}
  function automatic logic [32:0] ref_shift(input logic [1:0] k, input logic s,
                                            input logic [4:0] im, input logic [7:0] ra,
                                            input logic [31:0] v, input logic c);
    int a;
    int r;
    logic [31:0] o;
    logic co;
    if (!s) begin
      if (im == 0) begin
        if (k == 2'b00) return {c, v};
        if (k == 2'b11) return {v[0], c, v[31:1]};
        a = 32;
      end else begin
        a = int'(im);
      end
    end else begin
      if (ra == 0) return {c, v};
      a = int'(ra);
    end
    case (k)
      2'b00: begin
        if (a > 32)       begin o = '0; co = 1'b0; end
        else if (a == 32) begin o = '0; co = v[0]; end
        else              begin o = v << a; co = v[32-a]; end
      end
      2'b01: begin
        if (a > 32)       begin o = '0; co = 1'b0; end
        else if (a == 32) begin o = '0; co = v[31]; end
        else              begin o = v >> a; co = v[a-1]; end
      end
      2'b10: begin
        if (a >= 32) begin o = {32{v[31]}}; co = v[31]; end
        else         begin o = $signed(v) >>> a; co = v[a-1]; end
      end
      default: begin
        r = a % 32;
        if (r == 0) begin o = v; co = v[31]; end
        else        begin o = (v >> r) | (v << (32 - r)); co = v[r-1]; end
      end
    endcase
    return {co, o};
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    n_checks++;
    if ({carry_q, op_q} !== exp) begin
      n_fails++;
      $display("FAIL %s: actual op=%h carry=%b expected op=%h carry=%b",
               tag, op_q, carry_q, exp[31:0], exp[32]);
    end
  endtask

  // Drive one vector at a falling edge, compare at the next falling edge
  task automatic apply(input logic [1:0] k, input logic s, input logic [4:0] im,
                       input logic [7:0] ra, input logic [31:0] v, input logic c,
                       input string tag);
    step_en     = 1'b1;
    shift_kind  = k;
    amt_src_reg = s;
    imm_amt     = im;
    reg_amt     = ra;
    rm          = v;
    c_in        = c;
    exp_q       = ref_shift(k, s, im, ra, v, c);
    @(negedge clk);
    check(tag, exp_q);
  endtask

  function automatic string imm_tag(input logic [1:0] k, input logic [4:0] im);
    if (im != 0) return "R3/R4 (R13)";
    case (k)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic string reg_tag(input logic [1:0] k, input int ra);
    if (ra == 0) return "R9";
    if (k == 2'b11) return "R12 (R13)";
    if (ra >= 32 && k == 2'b10) return "R11";
    if (ra >= 32) return "R10";
    return "R3/R4 (R13)";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int amts[14] = '{0, 1, 7, 16, 31, 32, 33, 63, 64, 65, 96, 128, 200, 255};
    logic [31:0] pats[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hF0F0_1234, 32'h0000_0000};
    n_checks    = 0;
    n_fails     = 0;
    rst_n       = 1'b0;
    step_en     = 1'b0;
    amt_src_reg = 1'b0;
    shift_kind  = 2'b00;
    imm_amt     = '0;
    reg_amt     = '0;
    rm          = '0;
    c_in        = 1'b0;

    // R1: reset state, with busy inputs
    repeat (2) @(negedge clk);
    step_en = 1'b1;
    rm      = 32'hDEAD_BEEF;
    c_in    = 1'b1;
    @(negedge clk);
    check("R1", 33'h0);
    step_en = 1'b0;
    rst_n   = 1'b1;
    @(negedge clk);
    check("R1", 33'h0);

    // Instruction-field amounts, every kind and every amount
    for (int k = 0; k < 4; k++) begin
      for (int im = 0; im < 32; im++) begin
        for (int p = 0; p < 4; p++) begin
          apply(2'(k), 1'b0, 5'(im), 8'($urandom), pats[p] ^ 32'(p * im),
                1'(p), imm_tag(2'(k), 5'(im)));
        end
      end
    end

    // Register amounts at the class edges
    for (int k = 0; k < 4; k++) begin
      foreach (amts[i]) begin
        for (int p = 0; p < 4; p++) begin
          apply(2'(k), 1'b1, 5'($urandom), 8'(amts[i]), pats[p], 1'(p + 1),
                reg_tag(2'(k), amts[i]));
        end
      end
    end

    // Random sweep over both sources
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k;
      logic [7:0] ra;
      logic       s;
      k  = 2'($urandom);
      s  = 1'($urandom);
      ra = 8'($urandom);
      apply(k, s, 5'($urandom), ra, $urandom, 1'($urandom),
            s ? reg_tag(k, int'(ra)) : "R3/R4 (R13)");
    end

    // R2: hold while the enable is low
    apply(2'b01, 1'b0, 5'd3, 8'd0, 32'h1234_5678, 1'b0, "R3/R4");
    for (int n = 0; n < 6; n++) begin
      step_en     = 1'b0;
      shift_kind  = 2'($urandom);
      amt_src_reg = 1'($urandom);
      imm_amt     = 5'($urandom);
      reg_amt     = 8'($urandom);
      rm          = $urandom;
      c_in        = 1'($urandom);
      @(negedge clk);
      check("R2", exp_q);
    end
    apply(2'b11, 1'b1, 5'd0, 8'd36, 32'h0000_0010, 1'b0, "R12 (R2 resume)");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule